// File: doc/BRIEF.md
# Gated Cascaded Pacer Clock Generator

This block makes the periodic start-of-conversion pulse for an analog sampling front end. Two 16-bit down-counters are chained. The lower stage divides edges of a reference source, and that source can be either a slow (1 MHz) or a fast (10 MHz) reference. The upper stage divides the terminal-count pulses of the lower stage. The upper stage's terminal count is the pacer pulse. Both stages share one gate. That gate is either forced high, or it follows an external trigger pin when a control bit allows it. This lets an external signal hold off or suspend pacing.

A third, independent down-counter serves as a general-purpose user counter. Its clock is the edge stream of an external pin. When a control bit is set, that pin is ANDed with an internal 100 kHz tick before edge detection. All the raw sources are synchronised into the system clock domain and turned into single-cycle enables. Each counter works as a rate generator: when it reaches terminal count it reloads its divisor and emits a one-cycle pulse. Software sets the divisors and the control bits through byte-wide writes.

Top module: `cascade_pacer`

## Requirements
- R1: After reset both outputs are low and stay low while no source edges arrive; the control byte resets to 0.
- R2: With lower divisor A and upper divisor B loaded, `pace_o` pulses once per A*B rising edges of the selected reference, each pulse exactly one clock cycle wide.
- R3: `src_sel_i`=1 selects `src_fast_i` as the lower-stage source and `src_sel_i`=0 selects `src_slow_i`; edges on the unselected reference have no effect on `pace_o`.
- R4: With control bit 0 (trigger gating) set, the shared pacer gate equals the synchronised `trig_pin_i`; while it is low both pacer stages hold their counts and `pace_o` stays low, and counting resumes from the held counts when it returns high.
- R5: With control bit 0 clear, the pacer gate is held high and `trig_pin_i` has no effect on pacing.
- R6: The user counter counts rising edges of `c0_pin_i` when control bit 1 is clear, and rising edges of (`c0_pin_i` AND `tick100k_i`) when control bit 1 is set; `c0_out_o` pulses once per divisor-many such edges.
- R7: Register map on `wr_addr_i`: 0 = control byte, 1/2 = user counter low/high byte, 3/4 = pacer lower stage low/high byte, 5/6 = pacer upper stage low/high byte. A low-byte write only stages the byte. A high-byte write forms the new divisor and restarts that stage from it; the stage emits no pulse in the cycle it restarts.
- R8: A divisor of 0 acts as 65536.
- R9: A divisor of 1 gives one output pulse for every counted edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel_i | input | 1 | Reference select: 1 fast, 0 slow (static) |
| src_slow_i | input | 1 | Slow (1 MHz) reference level |
| src_fast_i | input | 1 | Fast (10 MHz) reference level |
| tick100k_i | input | 1 | Internal 100 kHz tick level |
| c0_pin_i | input | 1 | External user-counter clock pin |
| trig_pin_i | input | 1 | External trigger pin (idles high) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| pace_o | output | 1 | Pacer start pulse, one cycle wide |
| c0_out_o | output | 1 | User counter terminal-count pulse |

## Verification
The bench builds the block with its defaults: a 16-bit counter width and a two-flop synchroniser. Keeping the full width puts the divisor-0 case, which behaves as 65536, within reach. The test drives all 65536 edges through the user counter. With small divisors, the product A*B stays low enough that random divisor pairs, random reference choices and noise on the unselected reference can each be checked in a few dozen edges. The gating, suspend and resume checks use exact edge counts, so a count that is lost or added during a gated interval shows up as a wrong pulse total.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
    localparam int ADDR_W = 3;
    localparam int NUM_STAGES = 3;

    // control byte: bit 0 trigger gating, bit 1 tick gating of the user counter
    typedef struct packed {
        logic tick_gate;
        logic trig_gate;
    } pacer_ctrl_t;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
endpackage

// File: rtl/lvl_sync.sv
module lvl_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d = stg_q;
        stg_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/div_stage.sv
module div_stage #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             gate_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] div_i,
    output logic             tc_o
);
    localparam int FULL_W = CNT_W + 1;

    typedef struct packed {
        logic [FULL_W-1:0] cnt;
        logic              tc;
    } stage_st_t;

    stage_st_t st_d, st_q;
    logic [FULL_W-1:0] reload;

    // a zero divisor stands for the full 2**CNT_W span
    assign reload = (div_i == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, div_i};

    always_comb begin
        st_d    = st_q;
        st_d.tc = 1'b0;
        if (load_i) begin
            st_d.cnt = reload;
        end else if (tick_i && gate_i) begin
            if (st_q.cnt == FULL_W'(1)) begin
                st_d.cnt = reload;
                st_d.tc  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - FULL_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= {1'b1, {CNT_W{1'b0}}};
            st_q.tc  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tc_o = st_q.tc;
endmodule

// File: rtl/cascade_pacer.sv
module cascade_pacer
    import pacer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_sel_i,
    input  logic              src_slow_i,
    input  logic              src_fast_i,
    input  logic              tick100k_i,
    input  logic              c0_pin_i,
    input  logic              trig_pin_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    output logic              pace_o,
    output logic              c0_out_o
);
    // divisors are written as a low byte and a high byte (CNT_W in 9..16)
    localparam int HI_W  = CNT_W - 8;
    localparam int NSRC  = 5;
    localparam int I_FST = 0;
    localparam int I_SLW = 1;
    localparam int I_TCK = 2;
    localparam int I_PIN = 3;
    localparam int I_TRG = 4;

    typedef struct packed {
        logic                             fast_prev;
        logic                             slow_prev;
        logic                             c0_prev;
        pacer_ctrl_t                      ctrl;
        logic [NUM_STAGES-1:0][7:0]       lo;
        logic [NUM_STAGES-1:0][CNT_W-1:0] div;
        logic [NUM_STAGES-1:0]            load;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NSRC-1:0]       raw_lvl, sync_lvl;
    logic                  c0_lvl;
    logic                  fast_edge, slow_edge, c0_edge;
    logic                  pacer_gate;
    logic [NUM_STAGES-1:0] stage_tick, stage_gate, stage_tc, stage_load;

    assign raw_lvl[I_FST] = src_fast_i;
    assign raw_lvl[I_SLW] = src_slow_i;
    assign raw_lvl[I_TCK] = tick100k_i;
    assign raw_lvl[I_PIN] = c0_pin_i;
    assign raw_lvl[I_TRG] = trig_pin_i;

    lvl_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_lvl),
        .q_o   (sync_lvl)
    );

    always_comb begin
        c0_lvl = st_q.ctrl.tick_gate ? (sync_lvl[I_PIN] & sync_lvl[I_TCK])
                                     : sync_lvl[I_PIN];
        fast_edge  = sync_lvl[I_FST] & ~st_q.fast_prev;
        slow_edge  = sync_lvl[I_SLW] & ~st_q.slow_prev;
        c0_edge    = c0_lvl & ~st_q.c0_prev;
        pacer_gate = st_q.ctrl.trig_gate ? sync_lvl[I_TRG] : 1'b1;

        st_d           = st_q;
        st_d.fast_prev = sync_lvl[I_FST];
        st_d.slow_prev = sync_lvl[I_SLW];
        st_d.c0_prev   = c0_lvl;
        st_d.load      = '0;

        if (wr_en_i) begin
            if (wr_addr_i == ADDR_CTRL) begin
                st_d.ctrl = pacer_ctrl_t'(wr_data_i[1:0]);
            end
            for (int i = 0; i < NUM_STAGES; i++) begin
                if (wr_addr_i == ADDR_W'(2 * i + 1)) begin
                    st_d.lo[i] = wr_data_i;
                end
                if (wr_addr_i == ADDR_W'(2 * i + 2)) begin
                    st_d.div[i]  = {wr_data_i[HI_W-1:0], st_q.lo[i]};
                    st_d.load[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stage_tick[0] = c0_edge;
    assign stage_gate[0] = 1'b1;
    assign stage_tick[1] = src_sel_i ? fast_edge : slow_edge;
    assign stage_gate[1] = pacer_gate;
    assign stage_tick[2] = stage_tc[1];
    assign stage_gate[2] = pacer_gate;
    assign stage_load    = st_q.load;

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        div_stage #(.CNT_W(CNT_W)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (stage_tick[g]),
            .gate_i (stage_gate[g]),
            .load_i (stage_load[g]),
            .div_i  (st_q.div[g]),
            .tc_o   (stage_tc[g])
        );
    end

    assign c0_out_o = stage_tc[0];
    assign pace_o   = stage_tc[2];
endmodule

// File: rtl/pacer_checker.sv
module pacer_checker (
    input logic clk,
    input logic rst_n,
    input logic pace,
    input logic c0_out,
    input logic gate,
    input logic tc1,
    input logic c0_load
);
    p_pace_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pace |=> !pace);

    p_pace_from_lower_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pace |-> $past(tc1));

    p_gate_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> !pace);

    p_c0_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        c0_out |=> !c0_out);

    p_load_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        c0_load |=> !c0_out);
endmodule

bind cascade_pacer pacer_checker u_pacer_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pace    (pace_o),
    .c0_out  (c0_out_o),
    .gate    (pacer_gate),
    .tc1     (stage_tc[1]),
    .c0_load (stage_load[0])
);

// File: tb/tb_cascade_pacer.sv
module tb_cascade_pacer;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_sel = 1'b1, src_slow = 1'b0, src_fast = 1'b0;
    logic       tick = 1'b0, pin = 1'b0, trig = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pace, c0_out;

    int checks = 0, errors = 0;
    int pace_cnt = 0, c0_cnt = 0;

    always #(CLK_P / 2) clk = ~clk;

    cascade_pacer dut (
        .clk(clk), .rst_n(rst_n), .src_sel_i(src_sel), .src_slow_i(src_slow),
        .src_fast_i(src_fast), .tick100k_i(tick), .c0_pin_i(pin),
        .trig_pin_i(trig), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .pace_o(pace), .c0_out_o(c0_out)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            pace_cnt <= pace_cnt + int'(pace);
            c0_cnt   <= c0_cnt + int'(c0_out);
        end
    end

    function automatic int exp_pulses(int n, int a, int b);
        return n / (a * b);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(int addr, int data);
        wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        repeat (8) @(negedge clk);
        #1;
    endtask

    task automatic set_div(int stage, int val);
        wr(2 * stage + 1, val & 8'hff);
        wr(2 * stage + 2, (val >> 8) & 8'hff);
    endtask

    task automatic pacer_div(int a, int b);
        set_div(1, a);
        set_div(2, b);
        drain();
    endtask

    // which: 0 fast, 1 slow, 2 user pin; noise toggles the other reference
    task automatic edges(int which, int n, int half, bit noise);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            case (which)
                0: begin src_fast = 1'b1; if (noise) src_slow = 1'($urandom % 2); end
                1: begin src_slow = 1'b1; if (noise) src_fast = 1'($urandom % 2); end
                default: pin = 1'b1;
            endcase
            repeat (half) @(negedge clk);
            src_fast = 1'b0; src_slow = 1'b0; pin = 1'b0;
            repeat (half - 1) @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'h5eed1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        drain();
        // R1 reset state
        chk("R1 pace", int'(pace), 0);
        chk("R1 c0", int'(c0_out), 0);
        chk("R1 idle pulses", pace_cnt + c0_cnt, 0);

        // R2 cascade count, A=2 B=3
        src_sel = 1'b1;
        pacer_div(2, 3);
        base = pace_cnt;
        edges(0, 5, 2, 0); drain();
        chk("R2 before A*B", pace_cnt - base, 0);
        edges(0, 1, 2, 0); drain();
        chk("R2 at A*B", pace_cnt - base, 1);
        edges(0, 12, 2, 0); drain();
        chk("R2 three periods", pace_cnt - base, 3);

        // R3 source select
        base = pace_cnt;
        edges(1, 20, 2, 0); drain();
        chk("R3 slow ignored when fast selected", pace_cnt - base, 0);
        src_sel = 1'b0;
        pacer_div(2, 3);
        base = pace_cnt;
        edges(1, 6, 2, 0); drain();
        chk("R3 slow selected", pace_cnt - base, 1);
        edges(0, 18, 2, 0); drain();
        chk("R3 fast ignored when slow selected", pace_cnt - base, 1);
        src_sel = 1'b1;

        // R4 trigger gating: hold and resume
        wr(0, 1);
        pacer_div(2, 3);
        base = pace_cnt;
        edges(0, 4, 2, 0); drain();
        chk("R4 partial", pace_cnt - base, 0);
        trig = 1'b0; repeat (4) @(negedge clk);
        edges(0, 10, 2, 0); drain();
        chk("R4 gate low blocks", pace_cnt - base, 0);
        trig = 1'b1; repeat (4) @(negedge clk);
        edges(0, 2, 2, 0); drain();
        chk("R4 resume from held count", pace_cnt - base, 1);

        // R5 trigger pin ignored when gating disabled
        wr(0, 0);
        trig = 1'b0;
        pacer_div(2, 3);
        base = pace_cnt;
        edges(0, 6, 2, 0); drain();
        chk("R5 trig low ignored", pace_cnt - base, 1);
        trig = 1'b1;

        // R7 low byte only stages, high byte restarts
        pacer_div(2, 3);
        base = pace_cnt;
        edges(0, 3, 2, 0);
        wr(3, 2); drain();
        edges(0, 3, 2, 0); drain();
        chk("R7 low write no restart", pace_cnt - base, 1);
        base = pace_cnt;
        edges(0, 3, 2, 0);
        pacer_div(2, 3);
        edges(0, 5, 2, 0); drain();
        chk("R7 high write restarts", pace_cnt - base, 0);

        // R6 user counter clock gating
        set_div(0, 3); drain();
        base = c0_cnt;
        edges(2, 3, 2, 0); drain();
        chk("R6 pin alone", c0_cnt - base, 1);
        wr(0, 2); drain();
        base = c0_cnt;
        edges(2, 6, 2, 0); drain();
        chk("R6 tick low blocks", c0_cnt - base, 0);
        tick = 1'b1; repeat (4) @(negedge clk);
        edges(2, 3, 2, 0); drain();
        chk("R6 tick high passes", c0_cnt - base, 1);
        tick = 1'b0;
        wr(0, 0);

        // R9 divisor one
        set_div(0, 1); drain();
        base = c0_cnt;
        edges(2, 5, 2, 0); drain();
        chk("R9 div one", c0_cnt - base, 5);

        // R8 divisor zero spans 65536
        set_div(0, 0); drain();
        base = c0_cnt;
        edges(2, 65535, 1, 0); drain();
        chk("R8 before 65536", c0_cnt - base, 0);
        edges(2, 1, 1, 0); drain();
        chk("R8 at 65536", c0_cnt - base, 1);

        // R2/R3 random divisors, reference choice and noise
        for (int it = 0; it < 8; it++) begin
            int a, b, n, sel;
            a = 1 + int'($urandom % 4);
            b = 1 + int'($urandom % 4);
            n = int'($urandom % 40);
            sel = int'($urandom % 2);
            src_sel = 1'(sel);
            pacer_div(a, b);
            base = pace_cnt;
            edges(sel != 0 ? 0 : 1, n, 2, 1); drain();
            chk("R2 R3 random", pace_cnt - base, exp_pulses(n, a, b));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule